// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the host write port of a word-wide parallel NOR-style flash. It turns the stream of host write cycles into instructions. Each write carries a 16-bit address and a 16-bit data word. The decoder checks the two-cycle unlock preamble and then reads the command byte. An erase needs more than that: a second unlock pair and a confirm byte. When an instruction completes, the decoder raises a one-cycle start pulse for the program/erase engine or for the read path.

The decoder drives the current read mode. It selects array data, the signature word or engine status, and it supplies the signature word for the two low read-address bits. Any write that breaks a sequence sends the decoder back to read-array at sequence position zero. While the engine reports busy, host writes are ignored. The one exception is a reset command after the engine has flagged a failure.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `rd_mode` is 2'b00 (array) and `prog_go`, `erase_go`, `sig_go` and `rst_go` are all low.
- R2: An unlock pair is a write of low data byte AAh to address 555h, then a write of low data byte 55h to address 2AAh. Only address bits 10..0 and data bits 7..0 are compared, so values in address bits 15..11 and data bits 15..8 have no effect.
- R3: Program works as follows. After the unlock pair, a write of command byte A0h to address 555h gives no pulse. The next write raises `prog_go` for exactly one cycle, with `prog_addr`/`prog_data` equal to that write's address and data.
- R4: Chip erase works as follows. Unlock pair, then 80h to 555h, then a second unlock pair, then 10h to 555h. `erase_go` pulses for one cycle only after the sixth write, and none of the first five writes gives a pulse.
- R5: After the unlock pair, 90h to 555h pulses `sig_go` and sets `rd_mode` to 2'b01 (signature). In that mode, `sig_word` is 0020h for `rd_sel`=00, 00C1h for `rd_sel`=01, and 0000h when `rd_sel[1]` is 1. The upper byte is always 00h.
- R6: Command byte F0h pulses `rst_go` and selects array mode. This works as a bare single write to any address, and also as the write after an unlock pair, to any address.
- R7: Any of the following returns the decoder to sequence position zero and array mode with no pulse: a wrong unlock value, a wrong confirm address or byte, or a command byte written to the wrong address.
- R8: While `eng_busy` is 1 and `eng_fail` is 0, every write is ignored. No pulse appears and the sequence position is kept. While both are 1, a bare F0h is accepted and pulses `rst_go`.
- R9: While `eng_busy` is 1, `rd_mode` is 2'b10 (status) in the same cycle, whatever the sequence state or address.
- R10: Any accepted write other than the one completing a signature instruction leaves signature mode and selects array mode.
- R11: Command bytes other than F0h, 90h, A0h and 80h after an unlock pair are treated as unrecognised. This includes the reserved 00h and 20h. They give no pulse and no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; low byte carries commands |
| eng_busy | input | 1 | Program/erase engine running |
| eng_fail | input | 1 | Engine has flagged a failure |
| rd_sel | input | 2 | Read address bits 1..0 for signature lookup |
| rd_mode | output | 2 | 00 array, 01 signature, 10 status |
| sig_word | output | DATA_W | Signature word in signature mode, else zero |
| prog_go | output | 1 | Start-program pulse |
| prog_addr | output | ADDR_W | Address for the program operation |
| prog_data | output | DATA_W | Data for the program operation |
| erase_go | output | 1 | Start-chip-erase pulse |
| sig_go | output | 1 | Entered signature mode pulse |
| rst_go | output | 1 | Return-to-read-array pulse |

## Verification
Each write is captured on the clock edge that sees `wr_stb`. Any start pulse or mode change it causes is therefore visible for exactly one cycle, beginning at that edge. The bench drives each strobe for one cycle and samples at the next falling edge. Starting the next write waits a further edge, so a later sample also shows the pulse has gone.

Status selection follows `eng_busy` with no register in between, and `sig_word` follows `rd_sel` the same way. The bench checks both a short delay after it changes the input. The whole 256-value command byte space is swept after an unlock pair, and all 32 settings of the ignored high address bits are swept through the unlock compare.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int CMP_AW = 11;
    localparam int CB     = 8;

    localparam logic [CMP_AW-1:0] UNL_A_ADDR = 11'h555;
    localparam logic [CMP_AW-1:0] UNL_B_ADDR = 11'h2AA;
    localparam logic [CB-1:0]     UNL_A_DATA = 8'hAA;
    localparam logic [CB-1:0]     UNL_B_DATA = 8'h55;

    localparam logic [CB-1:0] CMD_RESET = 8'hF0;
    localparam logic [CB-1:0] CMD_SIG   = 8'h90;
    localparam logic [CB-1:0] CMD_PROG  = 8'hA0;
    localparam logic [CB-1:0] CMD_ERASE = 8'h80;
    localparam logic [CB-1:0] CMD_CONF  = 8'h10;

    localparam logic [15:0] SIG_MFR = 16'h0020;
    localparam logic [15:0] SIG_DEV = 16'h00C1;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'b00,
        RM_SIG    = 2'b01,
        RM_STATUS = 2'b10
    } rd_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERS3,
        SQ_ERS4,
        SQ_ERS5
    } seq_e;

    typedef struct packed {
        logic          unl_a;
        logic          unl_b;
        logic          cmd_addr;
        logic [CB-1:0] cmd;
    } wr_class_t;

    typedef struct packed {
        logic prog;
        logic erase;
        logic sig;
        logic rst;
    } pulse_t;

    function automatic logic [15:0] sig_code(input logic [1:0] sel);
        if (sel[1])
            return 16'h0000;
        return sel[0] ? SIG_DEV : SIG_MFR;
    endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wr_class_t         cls
);

    logic [CMP_AW-1:0] a_lo;
    logic [CB-1:0]     d_lo;

    assign a_lo = addr[CMP_AW-1:0];
    assign d_lo = data[CB-1:0];

    always_comb begin
        cls.unl_a    = (a_lo == UNL_A_ADDR) && (d_lo == UNL_A_DATA);
        cls.unl_b    = (a_lo == UNL_B_ADDR) && (d_lo == UNL_B_DATA);
        cls.cmd_addr = (a_lo == UNL_A_ADDR);
        cls.cmd      = d_lo;
    end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  wr_class_t         cls,
    input  logic              eng_busy,
    input  logic              eng_fail,
    output rd_mode_e          base_mode,
    output pulse_t            pulse_q,
    output logic [ADDR_W-1:0] prog_addr_q,
    output logic [DATA_W-1:0] prog_data_q
);

    seq_e     state_q, state_d;
    rd_mode_e mode_q, mode_d;
    pulse_t   pulse_d;
    logic     accept;

    assign accept = wr_stb && (!eng_busy || eng_fail);

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        pulse_d = '0;
        if (accept) begin
            state_d = SQ_IDLE;
            mode_d  = RM_ARRAY;
            unique case (state_q)
                SQ_IDLE: begin
                    if (cls.unl_a)
                        state_d = SQ_UNL1;
                    else if (cls.cmd == CMD_RESET)
                        pulse_d.rst = 1'b1;
                end
                SQ_UNL1: begin
                    if (cls.unl_b)
                        state_d = SQ_UNL2;
                end
                SQ_UNL2: begin
                    if (cls.cmd == CMD_RESET)
                        pulse_d.rst = 1'b1;
                    else if (cls.cmd_addr) begin
                        if (cls.cmd == CMD_SIG) begin
                            pulse_d.sig = 1'b1;
                            mode_d      = RM_SIG;
                        end else if (cls.cmd == CMD_PROG)
                            state_d = SQ_PROG;
                        else if (cls.cmd == CMD_ERASE)
                            state_d = SQ_ERS3;
                    end
                end
                SQ_PROG: pulse_d.prog = 1'b1;
                SQ_ERS3: begin
                    if (cls.unl_a)
                        state_d = SQ_ERS4;
                end
                SQ_ERS4: begin
                    if (cls.unl_b)
                        state_d = SQ_ERS5;
                end
                SQ_ERS5: begin
                    if (cls.cmd_addr && cls.cmd == CMD_CONF)
                        pulse_d.erase = 1'b1;
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            mode_q      <= RM_ARRAY;
            pulse_q     <= '0;
            prog_addr_q <= '0;
            prog_data_q <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            pulse_q <= pulse_d;
            if (accept && state_q == SQ_PROG) begin
                prog_addr_q <= wr_addr;
                prog_data_q <= wr_data;
            end
        end
    end

    assign base_mode = mode_q;

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q));

    a_r3_prog_needs_write: assert property (@(posedge clk) disable iff (rst)
        pulse_q.prog |-> $past(wr_stb));

    a_r4_erase_from_last_step: assert property (@(posedge clk) disable iff (rst)
        pulse_q.erase |-> $past(state_q == SQ_ERS5));

    a_r7_pulse_ends_sequence: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |-> (state_q == SQ_IDLE));

    a_r8_busy_ignores_write: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && eng_busy && !eng_fail) |=> (pulse_q == '0) && $stable(state_q));

endmodule

// File: rtl/fcd_sig.sv
module fcd_sig
    import fcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              sig_mode,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word = '0;
        if (sig_mode)
            word[15:0] = sig_code(rd_sel);
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_fail,
    input  logic [1:0]        rd_sel,
    output logic [1:0]        rd_mode,
    output logic [DATA_W-1:0] sig_word,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_go,
    output logic              sig_go,
    output logic              rst_go
);

    wr_class_t cls;
    rd_mode_e  base_mode;
    pulse_t    pulse;

    fcd_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cls (
        .addr (wr_addr),
        .data (wr_data),
        .cls  (cls)
    );

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cls         (cls),
        .eng_busy    (eng_busy),
        .eng_fail    (eng_fail),
        .base_mode   (base_mode),
        .pulse_q     (pulse),
        .prog_addr_q (prog_addr),
        .prog_data_q (prog_data)
    );

    fcd_sig #(.DATA_W(DATA_W)) u_sig (
        .sig_mode (base_mode == RM_SIG && !eng_busy),
        .rd_sel   (rd_sel),
        .word     (sig_word)
    );

    assign rd_mode  = eng_busy ? RM_STATUS : base_mode;
    assign prog_go  = pulse.prog;
    assign erase_go = pulse.erase;
    assign sig_go   = pulse.sig;
    assign rst_go   = pulse.rst;

    a_r9_status_when_busy: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> (rd_mode == RM_STATUS));

    a_r5_sig_mode_after_pulse: assert property (@(posedge clk) disable iff (rst)
        (sig_go && !eng_busy) |-> (rd_mode == RM_SIG));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        eng_busy = 1'b0;
    logic        eng_fail = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [1:0]  rd_mode;
    logic [15:0] sig_word;
    logic        prog_go;
    logic [15:0] prog_addr;
    logic [15:0] prog_data;
    logic        erase_go;
    logic        sig_go;
    logic        rst_go;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .eng_fail(eng_fail),
        .rd_sel(rd_sel), .rd_mode(rd_mode), .sig_word(sig_word),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_go(erase_go), .sig_go(sig_go), .rst_go(rst_go)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // pulse vector order {prog, erase, sig, rst}
    task automatic chk_p(input string req, input logic [3:0] exp);
        chk(req, {28'd0, prog_go, erase_go, sig_go, rst_go}, {28'd0, exp});
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic unlock(input logic [15:0] hi);
        wr(16'h0555 | hi, 16'h00AA | hi);
        wr(16'h02AA | hi, 16'h0055 | hi);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset mode", {30'd0, rd_mode}, 32'd0);
        chk_p("R1 reset pulses", 4'b0000);

        // R9 status in same cycle as busy
        eng_busy = 1'b1; #1;
        chk("R9 status while busy", {30'd0, rd_mode}, 32'd2);
        eng_busy = 1'b0; #1;
        chk("R9 array after busy", {30'd0, rd_mode}, 32'd0);

        // R5 signature
        unlock(16'h0000);
        wr(16'h0555, 16'h0090);
        chk_p("R5 sig pulse", 4'b0010);
        chk("R5 sig mode", {30'd0, rd_mode}, 32'd1);
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0]; #1;
            chk("R5 sig word", {16'd0, sig_word},
                {16'd0, (s >= 2) ? 16'h0000 : (s == 1 ? 16'h00C1 : 16'h0020)});
        end
        eng_busy = 1'b1; #1;
        chk("R9 status overrides signature", {30'd0, rd_mode}, 32'd2);
        eng_busy = 1'b0;

        // R10 any write leaves signature mode
        wr(16'h0000, 16'h1234);
        chk("R10 leaves sig", {30'd0, rd_mode}, 32'd0);
        chk_p("R10 no pulse", 4'b0000);

        // R3 program
        unlock(16'h0000);
        chk_p("R3 no pulse on unlock", 4'b0000);
        wr(16'h0555, 16'h00A0);
        chk_p("R3 no pulse on setup", 4'b0000);
        wr(16'h7ABC, 16'hBEEF);
        chk_p("R3 prog pulse", 4'b1000);
        chk("R3 prog addr", {16'd0, prog_addr}, 32'h7ABC);
        chk("R3 prog data", {16'd0, prog_data}, 32'hBEEF);
        @(negedge clk);
        chk_p("R3 pulse one cycle", 4'b0000);

        // R4 erase
        unlock(16'h0000);
        wr(16'h0555, 16'h0080);
        chk_p("R4 no pulse cycle3", 4'b0000);
        unlock(16'h0000);
        chk_p("R4 no pulse cycle5", 4'b0000);
        wr(16'h0555, 16'h0010);
        chk_p("R4 erase pulse", 4'b0100);
        @(negedge clk);
        chk_p("R4 pulse one cycle", 4'b0000);

        // R7 broken second unlock and wrong confirm address
        unlock(16'h0000);
        wr(16'h0555, 16'h0080);
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0056);
        wr(16'h0555, 16'h0010);
        chk_p("R7 bad second unlock", 4'b0000);
        unlock(16'h0000);
        wr(16'h0555, 16'h0080);
        unlock(16'h0000);
        wr(16'h0556, 16'h0010);
        chk_p("R7 bad confirm addr", 4'b0000);
        unlock(16'h0000);
        wr(16'h0554, 16'h0090);
        chk_p("R7 cmd at wrong addr", 4'b0000);
        chk("R7 stays array", {30'd0, rd_mode}, 32'd0);
        wr(16'h0455, 16'h00AA);
        wr(16'h02AA, 16'h0055);
        wr(16'h0555, 16'h0090);
        chk_p("R7 bad first unlock addr", 4'b0000);

        // R6 reset bare and after unlock
        wr(16'h1234, 16'h55F0);
        chk_p("R6 bare reset", 4'b0001);
        unlock(16'h0000);
        wr(16'h3333, 16'h00F0);
        chk_p("R6 unlocked reset", 4'b0001);

        // R8 busy ignores writes, keeps position
        unlock(16'h0000);
        eng_busy = 1'b1;
        wr(16'h0000, 16'h00F0);
        chk_p("R8 reset ignored while busy", 4'b0000);
        wr(16'h0555, 16'h00AA);
        chk_p("R8 write ignored while busy", 4'b0000);
        eng_busy = 1'b0;
        wr(16'h0555, 16'h00A0);
        wr(16'h0042, 16'h0F0F);
        chk_p("R8 position kept", 4'b1000);
        chk("R8 prog data after busy", {16'd0, prog_data}, 32'h0F0F);
        eng_busy = 1'b1;
        eng_fail = 1'b1;
        wr(16'h0000, 16'h00F0);
        chk_p("R8 reset accepted on fail", 4'b0001);
        eng_busy = 1'b0;
        eng_fail = 1'b0;

        // R2 high address/data bits ignored in unlock
        for (int k = 0; k < 32; k++) begin
            unlock(16'(k) << 11);
            wr(16'h0555 | (16'(k) << 11), 16'h0090);
            chk_p("R2 high bits ignored", 4'b0010);
        end

        // R11/R6/R3 sweep of every command byte
        for (int c = 0; c < 256; c++) begin
            logic [3:0] e1;
            logic [3:0] e2;
            e1 = (c == 'hF0) ? 4'b0001 : (c == 'h90) ? 4'b0010 : 4'b0000;
            e2 = (c == 'hA0) ? 4'b1000 : (c == 'h80) ? 4'b0000 : 4'b0001;
            unlock(16'h0000);
            wr(16'h0555, 16'(c));
            chk_p("R11 command sweep", e1);
            chk("R11 sweep mode", {30'd0, rd_mode}, (c == 'h90) ? 32'd1 : 32'd0);
            wr(16'h0000, 16'h00F0);
            chk_p("R11 follow-up", e2);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule